// File: doc/BRIEF.md
# Redundant Clock Failover Monitor

This block watches two redundant reference clocks from a fast, free-running sampling clock. It flags an input as failed when that input stops toggling. When the input currently in use fails and the other input is healthy, the block moves the selection to the other input.

Each reference is brought into the sampling domain through two flops. A per-input counter is cleared on every detected edge. A failure is declared when the counter reaches the nominal period count plus a safety margin. Failure flags are latched until an alarm clear.

The registered select output drives a downstream glitch-free clock multiplexer. A status copy reports which input is in use. A manual override hands the choice to software through the preferred-clock input.

Top module: `clk_failover_mon`

## Requirements
- R1: With LIMIT = PERIOD_CNT + MARGIN sampling cycles, an input whose every level lasts at most LIMIT sampling cycles is never flagged. An input held at one level, high or low, for more than LIMIT sampling cycles gets its bad flag set.
- R2: A bad flag stays high once set, until alarm_clr is asserted.
- R3: The two inputs are monitored independently. A failure on one input never sets the other input's flag.
- R4: With manual override low, if the selected input is flagged bad and the other is not, the select (0 = ref_clk0, 1 = ref_clk1) moves to the other input on the next sampling edge.
- R5: A failure of the unselected input sets only its flag and leaves the select unchanged.
- R6: If both inputs are flagged bad, the select stays where it is.
- R7: On the first sampling edge after reset the select loads pref_sel. It does not later return to pref_sel by itself after a failover.
- R8: While man_ovr is high, the select takes the value of pref_sel on each sampling edge and automatic failover is disabled. Bad flags still update. When override is released, failover resumes from the selection held at that moment.
- R9: A sampling edge with alarm_clr high clears both flags. A flag whose input is still stuck sets again on the following sampling edge.
- R10: clk_in_use always equals mux_sel. Both change only on sampling clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Fast free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk0 | input | 1 | Redundant reference clock 0 |
| ref_clk1 | input | 1 | Redundant reference clock 1 |
| pref_sel | input | 1 | Preferred input (0 = ref_clk0, 1 = ref_clk1) |
| man_ovr | input | 1 | Manual override: select follows pref_sel |
| alarm_clr | input | 1 | Clears both bad flags |
| bad0 | output | 1 | Latched failure flag of ref_clk0 |
| bad1 | output | 1 | Latched failure flag of ref_clk1 |
| clk_in_use | output | 1 | Status: input currently selected |
| mux_sel | output | 1 | Select line to the glitch-free clock multiplexer |

## Verification
On every cycle, the assertions check several rules: flags stay latched until a clear, a clear always takes effect, the select follows pref_sel under override, and a failover happens whenever the selected input is bad and the other is good. The bench sweeps the level length of a reference across the detection threshold to show exactly where flagging starts. It also shows through scenarios what the assertions cannot: that a failure on the secondary input leaves the selection alone, that the selection holds when both inputs are bad, that the initial choice follows pref_sel after reset, and that a flag re-arms when the input is still stuck.

// File: rtl/clk_failover_mon.sv
module clk_failover_mon #(
  parameter int PERIOD_CNT = 16,
  parameter int MARGIN     = 4
) (
  input  logic smp_clk,
  input  logic rst_n,
  input  logic ref_clk0,
  input  logic ref_clk1,
  input  logic pref_sel,
  input  logic man_ovr,
  input  logic alarm_clr,
  output logic bad0,
  output logic bad1,
  output logic clk_in_use,
  output logic mux_sel
);
  localparam int LIMIT = PERIOD_CNT + MARGIN;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [1:0]    s1, s2, s3, bad_q;
  logic [CW-1:0] cnt [2];
  logic          sel_q, init_q;

  wire [1:0] ref_in = {ref_clk1, ref_clk0};
  wire [1:0] edge_s = s2 ^ s3;
  wire [1:0] stuck  = {cnt[1] == LIM, cnt[0] == LIM};
  wire       fail   = bad_q[sel_q] && !bad_q[~sel_q];

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      bad_q <= '0;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      s1 <= ref_in;
      s2 <= s1;
      s3 <= s2;
      for (int i = 0; i < 2; i++) begin
        if (edge_s[i])        cnt[i] <= '0;
        else if (!stuck[i])   cnt[i] <= cnt[i] + 1'b1;
        if (alarm_clr)        bad_q[i] <= 1'b0;
        else if (stuck[i])    bad_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (!init_q || man_ovr) sel_q <= pref_sel;
      else if (fail)          sel_q <= ~sel_q;
    end
  end

  assign bad0       = bad_q[0];
  assign bad1       = bad_q[1];
  assign mux_sel    = sel_q;
  assign clk_in_use = sel_q;
endmodule

module clk_failover_mon_chk (
  input logic smp_clk,
  input logic rst_n,
  input logic pref_sel,
  input logic man_ovr,
  input logic alarm_clr,
  input logic bad0,
  input logic bad1,
  input logic clk_in_use,
  input logic mux_sel
);
  p_bad0_latched_r2: assert property (@(posedge smp_clk) disable iff (!rst_n)
    bad0 && !alarm_clr |=> bad0);
  p_bad1_latched_r2: assert property (@(posedge smp_clk) disable iff (!rst_n)
    bad1 && !alarm_clr |=> bad1);
  p_clear_takes_r9: assert property (@(posedge smp_clk) disable iff (!rst_n)
    alarm_clr |=> !bad0 && !bad1);
  p_override_follow_r8: assert property (@(posedge smp_clk) disable iff (!rst_n)
    man_ovr |=> mux_sel == $past(pref_sel));
  p_failover_r4: assert property (@(posedge smp_clk) disable iff (!rst_n)
    !man_ovr && ((!mux_sel && bad0 && !bad1) || (mux_sel && bad1 && !bad0))
    |=> mux_sel != $past(mux_sel));
  p_status_same_r10: assert property (@(negedge smp_clk) disable iff (!rst_n)
    clk_in_use == mux_sel);
endmodule

bind clk_failover_mon clk_failover_mon_chk chk_i (
  .smp_clk(smp_clk), .rst_n(rst_n), .pref_sel(pref_sel), .man_ovr(man_ovr),
  .alarm_clr(alarm_clr), .bad0(bad0), .bad1(bad1),
  .clk_in_use(clk_in_use), .mux_sel(mux_sel)
);

// File: tb/clk_failover_mon_tb.sv
module clk_failover_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCNT = 8;
  localparam int MRG  = 2;
  localparam int LIM  = PCNT + MRG;

  logic smp_clk = 0, rst_n = 0;
  logic r0 = 0, r1 = 0;
  logic pref_sel = 0, man_ovr = 0, alarm_clr = 0;
  logic bad0, bad1, clk_in_use, mux_sel;
  int   half0 = 2, half1 = 2, cur0 = 0, cur1 = 0, c0 = 0, c1 = 0;
  logic sv0 = 0, sv1 = 0;
  int   total = 0, fails = 0;

  always #(CLK_PERIOD/2) smp_clk = ~smp_clk;

  clk_failover_mon #(.PERIOD_CNT(PCNT), .MARGIN(MRG)) dut_i (
    .smp_clk(smp_clk), .rst_n(rst_n), .ref_clk0(r0), .ref_clk1(r1),
    .pref_sel(pref_sel), .man_ovr(man_ovr), .alarm_clr(alarm_clr),
    .bad0(bad0), .bad1(bad1), .clk_in_use(clk_in_use), .mux_sel(mux_sel));

  always @(negedge smp_clk) begin
    if (half0 == 0) begin r0 = sv0; cur0 = 0; c0 = 0; end
    else begin
      if (cur0 == 0) cur0 = half0;
      c0++;
      if (c0 >= cur0) begin r0 = ~r0; c0 = 0; cur0 = half0; end
    end
    if (half1 == 0) begin r1 = sv1; cur1 = 0; c1 = 0; end
    else begin
      if (cur1 == 0) cur1 = half1;
      c1++;
      if (c1 >= cur1) begin r1 = ~r1; c1 = 0; cur1 = half1; end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int k = 0; k < n; k++) @(negedge smp_clk);
  endtask

  task automatic clr_pulse();
    @(negedge smp_clk) alarm_clr = 1;
    @(negedge smp_clk) alarm_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R2 reset bad0", bad0, 0);
    chk("R2 reset bad1", bad1, 0);
    rst_n = 1;
    wait_n(3);
    chk("R7 init sel pref0", mux_sel, 0);

    // R1 / R3 / R5 sweep of level length on the secondary input
    for (int h = 1; h <= LIM + 3; h++) begin
      half1 = h;
      wait_n(4 * h + 12);
      chk($sformatf("R1 h=%0d bad1", h), bad1, logic'(h > LIM));
      chk($sformatf("R3 h=%0d bad0", h), bad0, 0);
      chk($sformatf("R5 h=%0d sel", h), mux_sel, 0);
      half1 = 2;
      wait_n(h + 8);
      clr_pulse();
      chk($sformatf("R9 h=%0d cleared", h), bad1, 0);
    end

    // R4 primary stuck high, secondary good
    sv0 = 1; half0 = 0;
    wait_n(LIM + 10);
    chk("R1 stuck high bad0", bad0, 1);
    chk("R4 failover to 1", mux_sel, 1);
    chk("R10 status", clk_in_use, 1);
    half0 = 2;
    wait_n(10);
    clr_pulse();
    wait_n(5);
    chk("R9 bad0 cleared", bad0, 0);
    chk("R7 no return to pref", mux_sel, 1);

    // R5 secondary stuck low, then R6 both bad
    sv0 = 0; half0 = 0;
    wait_n(LIM + 10);
    chk("R1 stuck low bad0", bad0, 1);
    chk("R5 sel kept", mux_sel, 1);
    sv1 = 1; half1 = 0;
    wait_n(LIM + 10);
    chk("R3 bad1", bad1, 1);
    chk("R6 both bad sel held", mux_sel, 1);

    // R9 clear while still stuck re-arms
    clr_pulse();
    chk("R9 cleared bad0", bad0, 0);
    chk("R9 cleared bad1", bad1, 0);
    wait_n(1);
    chk("R9 re-set bad0", bad0, 1);
    chk("R9 re-set bad1", bad1, 1);

    // R8 manual override
    man_ovr = 1; pref_sel = 0;
    wait_n(1);
    chk("R8 ovr sel0 despite bad0", mux_sel, 0);
    wait_n(5);
    chk("R8 no failover under ovr", mux_sel, 0);
    pref_sel = 1;
    wait_n(1);
    chk("R8 ovr sel1", mux_sel, 1);
    pref_sel = 0;
    wait_n(1);
    chk("R8 ovr sel0 again", mux_sel, 0);
    half1 = 2;
    wait_n(10);
    clr_pulse();
    wait_n(3);
    chk("R8 bad1 cleared under ovr", bad1, 0);
    chk("R8 bad0 re-set under ovr", bad0, 1);
    sv1 = 0; half1 = 0;
    wait_n(LIM + 10);
    chk("R8 bad1 sets under ovr", bad1, 1);
    half1 = 2;
    wait_n(10);
    clr_pulse();
    wait_n(3);
    man_ovr = 0;
    wait_n(3);
    chk("R8 failover after release", mux_sel, 1);

    // R7 reset with pref=1
    half0 = 2; half1 = 2;
    rst_n = 0; pref_sel = 1;
    wait_n(3);
    chk("R7 reset sel", mux_sel, 0);
    rst_n = 1;
    wait_n(3);
    chk("R7 init sel pref1", mux_sel, 1);
    chk("R10 status init", clk_in_use, 1);
    wait_n(LIM + 10);
    chk("R1 toggling no flag0", bad0, 0);
    chk("R1 toggling no flag1", bad1, 0);

    $display("test done: total=%0d bad=%0d", total, fails);
    $finish;
  end
endmodule